// File: doc/BRIEF.md
# Multi-Precision Signed Booth Multiplier

This block multiplies two's-complement operands with a single radix-4 Booth partial-product array. The array can be split into independent lanes. A 3-bit mode input selects the lane layout. In the wide layout the array forms one W×W product. In the other layouts it forms one or two products of half width, or one to four products of quarter width, and all lanes in a layout are computed in the same pass. With the default W = 16, that means 16×16, 8×8 and 4×4 lanes. Each lane's signed product is written into its own field of the 2W-bit result. Lanes that are not active, and multiplier bits that lie outside the active lanes, contribute nothing.

The array never sign-extends a row. Each row's sign bit is stored inverted, and every active lane receives its own precomputed constant that offsets those inverted bits. The "+1" that completes a negated row is folded into the row's least significant bit, and any carry from that fold goes into the next column up. Carries are cut at every lane boundary inside the carry-save chain and again in the final adder, so one lane cannot disturb its neighbour.

Operands enter through a valid/ready handshake. The result leaves through a second handshake, from one output register. An operand set is accepted whenever the output register is empty or is being emptied in the same cycle. While the consumer holds off, the result stays on the output unchanged. A stall on the output pushes back on the input in the same cycle.

Top module: `prec_booth_mul`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operand set accepted on a clock edge (`in_valid && in_ready`) shows up on `out_prod`, with `out_valid` high, after that edge. With no new acceptance, `out_valid` drops after an edge at which `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` does not change.
- R3: Mode 3'b110 gives the full 2W-bit signed product of `in_mcand` and `in_mplier` on `out_prod`.
- R4: Mode 3'b100 gives the signed product of bits [7:0] of both operands on `out_prod[15:0]`. `out_prod[31:16]` is zero.
- R5: Mode 3'b101 computes two 8-bit lanes. Lane 0 is bits [7:0] and goes to `out_prod[15:0]`. Lane 1 multiplies `in_mcand[15:8]` by `in_mplier[15:8]` and goes to `out_prod[31:16]`.
- R6: Mode 3'b011 computes four 4-bit lanes. Lane k multiplies bits [4k+3:4k] of both operands and places its 8-bit signed product in `out_prod[8k+7:8k]`.
- R7: Mode 3'b010 computes 4-bit lanes 0, 1 and 2 as in R6. `out_prod[31:24]` is zero.
- R8: Mode 3'b001 computes 4-bit lanes 0 and 1 as in R6. `out_prod[31:16]` is zero.
- R9: Mode 3'b000 computes 4-bit lane 0 only, into `out_prod[7:0]`. `out_prod[31:8]` is zero.
- R10: Operand bits outside the active lanes of a mode have no effect on `out_prod`.
- R11: The unused mode code 3'b111 gives an all-zero `out_prod`.
- R12: During and right after reset, `out_valid` is low and `out_prod` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_mode | input | 3 | Lane layout code |
| in_mcand | input | W | Multiplicand, two's complement per lane |
| in_mplier | input | W | Multiplier, two's complement per lane |
| out_valid | output | 1 | Result held on `out_prod` is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_prod | output | 2W | Lane products, each in its own field |

## Verification
The bench aims at lane minima such as -8×-8, -128×-128 and -32768×-32768. These are the only cases where the -2 digit has to produce a positive row one beyond the lane's range. A design that mishandles the folded "+1" or the inverted sign bit returns the wrong sign or magnitude there. Neighbouring lanes are loaded with all-ones and all-minimum patterns so that every lane carries out of its top column. If a carry is not cut, the lane above it reads one too high. Operand bits outside the active lanes are driven with random values, so ungated rows would leave non-zero junk in fields that must be zero. A long output stall with a pending input checks that the result holds and that nothing is taken early.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
package pbm_pkg;

  // Lane layout codes presented on the mode input
  typedef enum logic [2:0] {
    MD_Q1  = 3'b000,
    MD_Q2  = 3'b001,
    MD_Q3  = 3'b010,
    MD_Q4  = 3'b011,
    MD_H1  = 3'b100,
    MD_H2  = 3'b101,
    MD_F1  = 3'b110,
    MD_RSV = 3'b111
  } mode_t;

  // Lane width class: quarter, half or full operand width
  typedef enum logic [1:0] {
    WS_QTR  = 2'd0,
    WS_HALF = 2'd1,
    WS_FULL = 2'd2
  } wsel_t;

  // Constant that cancels the inverted sign bits of every row of one lane,
  // taken modulo the lane's 2*lw-bit result field.
  function automatic logic [63:0] lane_corr(input int lw);
    logic [63:0] acc;
    acc = '0;
    for (int j = 0; j < lw / 2; j++) begin
      acc = acc + (64'd1 << (lw + 2 * j));
    end
    return (~acc + 64'd1) & ((64'd1 << (2 * lw)) - 64'd1);
  endfunction

  // Columns into which carries must not enter for a given lane width
  function automatic logic [63:0] lane_kill(input int lw, input int ow);
    logic [63:0] acc;
    acc = '0;
    for (int k = 1; k * 2 * lw < ow; k++) begin
      acc = acc | (64'd1 << (k * 2 * lw));
    end
    return acc;
  endfunction

endpackage

// File: rtl/pbm_mode_dec.sv
`timescale 1ns/1ps
module pbm_mode_dec
  import pbm_pkg::*;
(
  input  logic [2:0] mode,
  output wsel_t      wsel,
  output logic [3:0] lane_en,
  output logic [3:0] q_en
);

  always_comb begin
    case (mode_t'(mode))
      MD_F1:   begin wsel = WS_FULL; lane_en = 4'b0001; end
      MD_H1:   begin wsel = WS_HALF; lane_en = 4'b0001; end
      MD_H2:   begin wsel = WS_HALF; lane_en = 4'b0011; end
      MD_Q4:   begin wsel = WS_QTR;  lane_en = 4'b1111; end
      MD_Q3:   begin wsel = WS_QTR;  lane_en = 4'b0111; end
      MD_Q2:   begin wsel = WS_QTR;  lane_en = 4'b0011; end
      MD_Q1:   begin wsel = WS_QTR;  lane_en = 4'b0001; end
      default: begin wsel = WS_QTR;  lane_en = 4'b0000; end
    endcase

    // Quarter-slice enables used to gate the multiplier before Booth recoding
    case (wsel)
      WS_FULL: q_en = {4{lane_en[0]}};
      WS_HALF: q_en = {{2{lane_en[1]}}, {2{lane_en[0]}}};
      default: q_en = lane_en;
    endcase
  end

endmodule

// File: rtl/pbm_booth_row.sv
`timescale 1ns/1ps
module pbm_booth_row #(
  parameter int W  = 16,
  parameter int LW = 4,
  parameter int R  = 0
) (
  input  logic [LW-1:0]  a_lane,
  input  logic [2:0]     trip,
  input  logic           en,
  output logic [2*W-1:0] row,
  output logic [2*W-1:0] cbit
);

  localparam int K    = (2 * R) / LW;
  localparam int J    = R - K * (LW / 2);
  localparam int BASE = 2 * K * LW + 2 * J;

  logic          one, two, neg;
  logic [LW:0]   mag, pp;

  always_comb begin
    one = trip[1] ^ trip[0];
    two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    neg = trip[2] & ~(trip[1] & trip[0]);
    mag = one ? {a_lane[LW-1], a_lane} : (two ? {a_lane, 1'b0} : '0);
    pp  = mag ^ {(LW + 1){neg}};
    row  = '0;
    cbit = '0;
    if (en) begin
      // inverted sign on top, +1 folded into the LSB, its carry one column up
      row[BASE +: LW+1] = {~pp[LW], pp[LW-1:1], pp[0] ^ neg};
      cbit[BASE + 1]    = pp[0] & neg;
    end
  end

endmodule

// File: rtl/pbm_seg_sum.sv
`timescale 1ns/1ps
module pbm_seg_sum #(
  parameter int OW   = 32,
  parameter int NOPS = 10
) (
  input  logic [OW-1:0] ops [NOPS],
  input  logic [OW-1:0] kill,
  output logic [OW-1:0] sum
);

  logic [OW-1:0] s, c, maj;
  logic          cin;

  always_comb begin
    s = ops[0];
    c = '0;
    // carry-save chain; carries never enter a lane's base column
    for (int i = 1; i < NOPS; i++) begin
      maj = (s & c) | (s & ops[i]) | (c & ops[i]);
      s   = s ^ c ^ ops[i];
      c   = (maj << 1) & ~kill;
    end
    // segmented ripple resolve
    cin = 1'b0;
    for (int b = 0; b < OW; b++) begin
      if (kill[b]) cin = 1'b0;
      sum[b] = s[b] ^ c[b] ^ cin;
      cin    = (s[b] & c[b]) | (s[b] & cin) | (c[b] & cin);
    end
  end

endmodule

// File: rtl/prec_booth_mul.sv
`timescale 1ns/1ps
module prec_booth_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_mode,
  input  logic [W-1:0]   in_mcand,
  input  logic [W-1:0]   in_mplier,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_prod
);
  import pbm_pkg::*;

  localparam int OW   = 2 * W;
  localparam int ROWS = W / 2;
  localparam int NQ   = 4;
  localparam int QW   = W / NQ;
  localparam int NWV  = 3;
  localparam int NOPS = ROWS + 2;

  wsel_t            wsel;
  logic [NQ-1:0]    lane_en, q_en;
  logic [W-1:0]     mplier_g;

  logic [OW-1:0]    row_v  [NWV][ROWS];
  logic [OW-1:0]    cyb_v  [NWV][ROWS];
  logic [OW-1:0]    cy_v   [NWV];
  logic [OW-1:0]    cst_v  [NWV];
  logic [OW-1:0]    kill_v [NWV];

  logic [OW-1:0]    ops [NOPS];
  logic [OW-1:0]    kill_s;
  logic [OW-1:0]    prod_c;

  pbm_mode_dec u_dec (
    .mode    (in_mode),
    .wsel    (wsel),
    .lane_en (lane_en),
    .q_en    (q_en)
  );

  // gate multiplier slices of inactive lanes so their digits recode to zero
  for (genvar q = 0; q < NQ; q++) begin : g_gate
    assign mplier_g[q*QW +: QW] = in_mplier[q*QW +: QW] & {QW{q_en[q]}};
  end

  // one partial-product array per lane width class
  for (genvar gv = 0; gv < NWV; gv++) begin : g_wv
    localparam int LW = QW << gv;
    localparam int NL = W / LW;
    localparam logic [63:0] KILL64 = lane_kill(LW, OW);
    localparam logic [63:0] CORR64 = lane_corr(LW);
    localparam logic [2*LW-1:0] CORR = CORR64[2*LW-1:0];

    logic [OW-1:0] cy_loc, cst_loc;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int K = (2 * r) / LW;
      localparam int J = r - K * (LW / 2);
      logic [2:0] trip;
      if (J == 0) begin : g_first
        assign trip = {mplier_g[2*r+1], mplier_g[2*r], 1'b0};
      end else begin : g_next
        assign trip = {mplier_g[2*r+1], mplier_g[2*r], mplier_g[2*r-1]};
      end
      pbm_booth_row #(.W(W), .LW(LW), .R(r)) u_row (
        .a_lane (in_mcand[K*LW +: LW]),
        .trip   (trip),
        .en     (lane_en[K]),
        .row    (row_v[gv][r]),
        .cbit   (cyb_v[gv][r])
      );
    end

    always_comb begin
      cy_loc  = '0;
      cst_loc = '0;
      for (int r = 0; r < ROWS; r++) cy_loc = cy_loc | cyb_v[gv][r];
      for (int k = 0; k < NL; k++) begin
        if (lane_en[k]) cst_loc[2*k*LW +: 2*LW] = CORR;
      end
    end

    assign cy_v[gv]   = cy_loc;
    assign cst_v[gv]  = cst_loc;
    assign kill_v[gv] = KILL64[OW-1:0];
  end

  // pick the array that matches the current width class
  always_comb begin
    int gi;
    gi = (wsel == WS_FULL) ? 2 : ((wsel == WS_HALF) ? 1 : 0);
    for (int r = 0; r < ROWS; r++) ops[r] = row_v[gi][r];
    ops[ROWS]     = cy_v[gi];
    ops[ROWS + 1] = cst_v[gi];
    kill_s        = kill_v[gi];
  end

  pbm_seg_sum #(.OW(OW), .NOPS(NOPS)) u_sum (
    .ops  (ops),
    .kill (kill_s),
    .sum  (prod_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_prod  <= prod_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/prec_booth_mul_chk.sv
`timescale 1ns/1ps
module prec_booth_mul_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     in_mode,
  input logic [W-1:0]   in_mcand,
  input logic [W-1:0]   in_mplier,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_prod
);

  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r1_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  a_r3_full_product: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 3'b110) |=>
      ($signed(out_prod) == ($signed($past(in_mcand)) * $signed($past(in_mplier)))));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 3'b100) |=> (out_prod[2*W-1:W] == '0));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 3'b000) |=> (out_prod[2*W-1:W/2] == '0));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 3'b111) |=> (out_prod == '0));

  a_r12_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_prod == '0));

endmodule

bind prec_booth_mul prec_booth_mul_chk #(.W(W)) u_chk (.*);

// File: tb/tb_prec_booth_mul.sv
`timescale 1ns/1ps
module tb_prec_booth_mul;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [2:0]    in_mode;
  logic [W-1:0]  in_mcand, in_mplier;
  logic [2*W-1:0] out_prod;

  always #5 clk = ~clk;

  prec_booth_mul #(.W(W)) dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_mode, .in_mcand, .in_mplier,
    .out_valid, .out_ready, .out_prod
  );

  int    total = 0;
  int    bad = 0;
  int    bp = 100;
  logic  fired = 1'b0;
  logic  done = 1'b0;
  logic  m_valid = 1'b0;
  logic [31:0] m_prod = '0;
  string m_tag = "R12";
  string tag_ovr = "";

  function automatic logic [31:0] ref_mul(input logic [2:0] md, input logic [15:0] a,
                                          input logic [15:0] b);
    int w;
    logic [3:0] on;
    logic [31:0] r;
    case (md)
      3'b110:  begin w = 16; on = 4'b0001; end
      3'b100:  begin w = 8;  on = 4'b0001; end
      3'b101:  begin w = 8;  on = 4'b0011; end
      3'b011:  begin w = 4;  on = 4'b1111; end
      3'b010:  begin w = 4;  on = 4'b0111; end
      3'b001:  begin w = 4;  on = 4'b0011; end
      3'b000:  begin w = 4;  on = 4'b0001; end
      default: begin w = 4;  on = 4'b0000; end
    endcase
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (on[k] && k * w < 16) begin
        longint sa, sb, p;
        sa = (longint'(a) >> (k * w)) & ((longint'(1) << w) - 1);
        sb = (longint'(b) >> (k * w)) & ((longint'(1) << w) - 1);
        if (sa >= (longint'(1) << (w - 1))) sa = sa - (longint'(1) << w);
        if (sb >= (longint'(1) << (w - 1))) sb = sb - (longint'(1) << w);
        p = sa * sb;
        r = r | (32'(p & ((longint'(1) << (2 * w)) - 1)) << (2 * k * w));
      end
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [2:0] md);
    case (md)
      3'b110:  return "R3";
      3'b100:  return "R4";
      3'b101:  return "R5";
      3'b011:  return "R6";
      3'b010:  return "R7";
      3'b001:  return "R8";
      3'b000:  return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 1'b0;
      m_prod  = '0;
      fired   = 1'b0;
    end else begin
      logic f;
      f = in_valid && (!m_valid || out_ready);
      fired = f;
      if (f) begin
        m_valid = 1'b1;
        m_prod  = ref_mul(in_mode, in_mcand, in_mplier);
        m_tag   = (tag_ovr != "") ? tag_ovr : mode_tag(in_mode);
      end else if (out_ready) begin
        m_valid = 1'b0;
      end else if (m_valid) begin
        m_tag = "R2";
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == m_valid, "R1", 32'(out_valid), 32'(m_valid));
      check(in_ready == (!m_valid || out_ready), "R1", 32'(in_ready),
            32'(!m_valid || out_ready));
      if (m_valid) check(out_prod == m_prod, m_tag, out_prod, m_prod);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
    out_ready = ($urandom_range(99) < bp);
  endtask

  task automatic send(input logic [2:0] md, input logic [15:0] a, input logic [15:0] b);
    in_valid  = 1'b1;
    in_mode   = md;
    in_mcand  = a;
    in_mplier = b;
    do step(); while (!fired);
    in_valid = 1'b0;
  endtask

  logic [15:0] da [8] = '{16'h8888, 16'h8080, 16'h8000, 16'hFFFF,
                          16'h7777, 16'h7FFF, 16'h0000, 16'h1234};
  logic [15:0] db [8] = '{16'h8888, 16'h8080, 16'h8000, 16'hFFFF,
                          16'h8888, 16'h7FFF, 16'hABCD, 16'hFEDC};
  logic [2:0]  narrow [4] = '{3'b000, 3'b001, 3'b010, 3'b100};

  initial begin
    in_valid = 1'b0; in_mode = '0; in_mcand = '0; in_mplier = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R12: state held in reset
    check(out_valid == 1'b0, "R12", 32'(out_valid), 32'd0);
    check(out_prod == '0, "R12", out_prod, 32'd0);
    #1;
    rst_n = 1'b1;
    bp = 100;
    out_ready = 1'b1;
    step();
    check(out_valid == 1'b0, "R12", 32'(out_valid), 32'd0);

    // directed corners per mode: lane minima, all ones, carries at boundaries
    for (int md = 0; md < 8; md++)
      for (int p = 0; p < 8; p++) send(3'(md), da[p], db[p]);

    // random operands with random back-pressure (R1 handshake under load)
    bp = 60;
    for (int md = 0; md < 8; md++)
      for (int n = 0; n < 30; n++) send(3'(md), 16'($urandom), 16'($urandom));

    // R10: random bits outside the active lanes must not matter
    tag_ovr = "R10";
    for (int i = 0; i < 4; i++)
      for (int n = 0; n < 10; n++) begin
        logic [15:0] a;
        a = 16'($urandom);
        send(narrow[i], a, 16'($urandom) | 16'hFF00);
      end
    tag_ovr = "";

    // R2: long output stall with a waiting input
    bp = 100;
    repeat (3) step();
    bp = 0;
    send(3'b110, 16'h8000, 16'h8000);
    in_valid = 1'b1; in_mode = 3'b011; in_mcand = 16'h8F7E; in_mplier = 16'h98F1;
    repeat (6) step();
    check(out_prod == 32'h4000_0000, "R2", out_prod, 32'h4000_0000);
    bp = 100;
    do step(); while (!fired);
    in_valid = 1'b0;
    repeat (4) step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule